// File: doc/BRIEF.md
# Sample-to-Flash Record Writer

This block turns a stream of 10-bit converter samples into bytes and stores them in an external serial flash that is organised in pages. The flash holds a one-page SRAM staging buffer. Each sample has a fixed offset removed and is cut down to its low eight bits. The block then sends it to the staging buffer as a short write command over an SPI master link. When the last byte position of the page has been written, the block sends a second command. That command copies the staging buffer into the next main-memory page without erasing it, on the assumption that the array was erased beforehand.

Recording is gated by a level input. A one-cycle flag marks the start of a fresh recording. Without that flag, a later recording continues from the byte and page where the previous one stopped. Every command waits for the flash's ready line. One sample can wait in a holding register while a command is on the wire. An arrival that finds that register still occupied is dropped and raises an overrun indication. When every page has been committed, the block ignores samples until a fresh recording is flagged.

Top module: `rec_flash_writer`

## Requirements
- R1: While reset is asserted and after its release with no stimulus, spiCsN and spiSck are high, overrun is low and no SPI frame is produced.
- R2: The stored byte equals (sample − 0x1D5) modulo 256. Examples: 0x211→0x3C, 0x000→0x2B, 0x3FF→0x2A, 0x1D4→0xFF.
- R3: Each stored sample produces exactly one CS-low frame of five bytes: 0x84, 0x00, {6'b0, addr[9:8]}, addr[7:0], data. Here addr is the 10-bit byte position in the staging buffer.
- R4: The SPI link uses mode 3. SCK is high whenever CS falls, bytes go out MSB first and are valid at rising SCK, one SCK period is four system clocks, and every frame holds whole bytes.
- R5: Byte positions run 0 to PAGE_BYTES−1. Right after the frame for the last position, a four-byte commit frame is sent: 0x88, {2'b00, page[11:6]}, {page[5:0], 2'b00}, 0x00. The following sample then goes to position 0 of page+1.
- R6: After a newRec pulse, the next stored sample goes to position 0 of page 0. This also applies when memory is full.
- R7: Without newRec, lowering and raising recordEn keeps the byte and page position, so new data is appended.
- R8: Once PAGE_COUNT pages are committed, samples produce no frames, even across recordEn toggles, until newRec is pulsed.
- R9: No frame begins while flashRdy is low. A sample accepted meanwhile is sent once flashRdy returns high.
- R10: A sampleValid pulse while recordEn is low produces no frame and does not set overrun.
- R11: One sample may wait while a command is in flight. A further sample that arrives while that one still waits is dropped and sets overrun. Overrun stays set until recordEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One-cycle strobe marking a new sample |
| sampleData | input | 10 | Raw converter sample |
| recordEn | input | 1 | Level that enables recording |
| newRec | input | 1 | Pulse: restart storage at page 0, byte 0 |
| flashRdy | input | 1 | Flash ready (high) / busy (low) |
| spiMiso | input | 1 | Serial data from the flash |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSck | output | 1 | Serial clock, idles high |
| spiMosi | output | 1 | Serial data to the flash |
| overrun | output | 1 | Sticky flag: a sample was dropped for lack of room |

## Verification
The bench decodes every SPI frame from the pins and compares it with frames it builds from the requirements. It aims at the page-boundary commit, the append-after-pause path, the full-memory lockout across recordEn toggles, and the restart after newRec. A design that mishandled these would commit late or at the wrong page number, restart at byte zero instead of appending, or keep writing past the last page. It also targets three timing cases. Samples on three consecutive cycles must keep exactly two, and a design with a bad holding register would lose or duplicate one. A held ready line must delay a command until release, and a design that ignored it would start while the flash is busy. Offsets at the ends of the input range check the wrap-around of the conversion.

// File: rtl/rfw_pkg.sv
package rfw_pkg;
  // Field widths fixed by the flash command format
  localparam int ADDR_FIELD_W = 10;
  localparam int PAGE_FIELD_W = 12;
  localparam logic [7:0] OP_BUF_WRITE = 8'h84;
  localparam logic [7:0] OP_PAGE_COMMIT = 8'h88;
  localparam logic [2:0] WRITE_LAST_BYTE = 3'd4;
  localparam logic [2:0] COMMIT_LAST_BYTE = 3'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_END
  } seq_state_t;

  typedef struct packed {
    logic       pop;       // move held sample into the transmit slot
    logic       advance;   // a buffer-write frame has completed
    logic       pageDone;  // a commit frame has completed
    logic       isCommit;  // frame type now on the wire
    logic [2:0] byteSel;   // byte number within the frame
  } ctrl_strobes_t;
endpackage

// File: rtl/rfw_spi_tx.sv
module rfw_spi_tx #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       load,
  input  logic [7:0] loadByte,
  input  logic       spiMiso,
  output logic       spiSck,
  output logic       spiMosi,
  output logic       busy,
  output logic       done
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF_CNT = CW'(DIV / 2);

  logic [CW-1:0] divCnt;
  logic [2:0]    bitCnt;
  logic [7:0]    shReg;
  logic          active;
  logic          misoBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      bitCnt  <= '0;
      shReg   <= '0;
      active  <= 1'b0;
      misoBit <= 1'b0;
    end else if (load) begin
      shReg  <= loadByte;
      active <= 1'b1;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (active) begin
      if (divCnt == HALF_CNT) misoBit <= spiMiso;
      if (divCnt == LAST_CNT) begin
        divCnt <= '0;
        shReg  <= {shReg[6:0], misoBit};
        if (bitCnt == 3'd7) active <= 1'b0;
        else bitCnt <= bitCnt + 3'd1;
      end else begin
        divCnt <= divCnt + CW'(1);
      end
    end
  end

  // Mode 3: low half first, rising edge in the middle of each bit
  assign spiSck  = active ? (divCnt >= HALF_CNT) : 1'b1;
  assign spiMosi = shReg[7];
  assign busy    = active;
  assign done    = active && (divCnt == LAST_CNT) && (bitCnt == 3'd7);

  a_r4_done_ends_byte: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
endmodule

// File: rtl/rfw_datapath.sv
module rfw_datapath
  import rfw_pkg::*;
#(
  parameter int SAMPLE_W   = 10,
  parameter int OFFSET     = 'h1D5,
  parameter int PAGE_BYTES = 528,
  parameter int PAGE_COUNT = 4096
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                recordEn,
  input  logic                newRec,
  input  ctrl_strobes_t       strb,
  output logic                holdFull,
  output logic                lastInPage,
  output logic [7:0]          frameByte,
  output logic                overrun
);
  localparam int BIDX_W = (PAGE_BYTES > 2) ? $clog2(PAGE_BYTES) : 1;
  localparam int PIDX_W = $clog2(PAGE_COUNT + 1);
  localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(PAGE_BYTES - 1);
  localparam logic [PIDX_W-1:0] PAGE_LIMIT = PIDX_W'(PAGE_COUNT);

  logic [SAMPLE_W-1:0]     diffFull;
  logic [SAMPLE_W-9:0]     diffHighUnused;
  logic [7:0]              convByte;
  logic [7:0]              holdByte;
  logic [7:0]              txData;
  logic [BIDX_W-1:0]       byteIdx;
  logic [PIDX_W-1:0]       pageIdx;
  logic                    newRecPend;
  logic                    memFull;
  logic                    acceptRaw;
  logic [ADDR_FIELD_W-1:0] addrField;
  logic [PAGE_FIELD_W-1:0] pageField;

  // Offset removal, then keep the low byte (wraps outside the window)
  assign diffFull       = sampleData - SAMPLE_W'(OFFSET);
  assign convByte       = diffFull[7:0];
  assign diffHighUnused = diffFull[SAMPLE_W-1:8];

  assign memFull    = (pageIdx == PAGE_LIMIT);
  assign acceptRaw  = sampleValid && recordEn && (!memFull || newRecPend);
  assign lastInPage = (byteIdx == LAST_BYTE);
  assign addrField  = ADDR_FIELD_W'(byteIdx);
  assign pageField  = PAGE_FIELD_W'(pageIdx);

  // Holding register and overrun
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdByte <= '0;
      holdFull <= 1'b0;
      txData   <= '0;
      overrun  <= 1'b0;
    end else begin
      if (strb.pop) txData <= holdByte;
      if (acceptRaw && (!holdFull || strb.pop)) begin
        holdByte <= convByte;
        holdFull <= 1'b1;
      end else if (strb.pop) begin
        holdFull <= 1'b0;
      end
      if (!recordEn) overrun <= 1'b0;
      else if (acceptRaw && holdFull && !strb.pop) overrun <= 1'b1;
    end
  end

  // Byte and page position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx    <= '0;
      pageIdx    <= '0;
      newRecPend <= 1'b0;
    end else begin
      if (newRec) newRecPend <= 1'b1;
      else if (strb.pop) newRecPend <= 1'b0;
      if (strb.pop && newRecPend) begin
        byteIdx <= '0;
        pageIdx <= '0;
      end else if (strb.advance) begin
        byteIdx <= lastInPage ? '0 : byteIdx + BIDX_W'(1);
      end else if (strb.pageDone) begin
        pageIdx <= pageIdx + PIDX_W'(1);
      end
    end
  end

  // Frame byte selection
  always_comb begin
    frameByte = 8'h00;
    if (strb.isCommit) begin
      case (strb.byteSel)
        3'd0:    frameByte = OP_PAGE_COMMIT;
        3'd1:    frameByte = {2'b00, pageField[11:6]};
        3'd2:    frameByte = {pageField[5:0], 2'b00};
        default: frameByte = 8'h00;
      endcase
    end else begin
      case (strb.byteSel)
        3'd0:    frameByte = OP_BUF_WRITE;
        3'd1:    frameByte = 8'h00;
        3'd2:    frameByte = {6'b000000, addrField[9:8]};
        3'd3:    frameByte = addrField[7:0];
        3'd4:    frameByte = txData;
        default: frameByte = 8'h00;
      endcase
    end
  end

  a_r5_byte_in_page: assert property (@(posedge clk) disable iff (!rstN)
    byteIdx < PAGE_BYTES);
  a_r8_page_bound: assert property (@(posedge clk) disable iff (!rstN)
    pageIdx <= PAGE_LIMIT);
  a_r11_overrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(holdFull));
  a_r10_hold_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdFull) |-> $past(recordEn));
endmodule

// File: rtl/rfw_ctrl.sv
module rfw_ctrl
  import rfw_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          flashRdy,
  input  logic          holdFull,
  input  logic          lastInPage,
  input  logic          spiDone,
  input  logic          spiBusy,
  output ctrl_strobes_t strb,
  output logic          spiLoad,
  output logic          spiCsN
);
  seq_state_t state;
  logic [2:0] byteNo;
  logic       isCommit;
  logic       commitPend;
  logic       startCmd;
  logic       frameEnd;

  assign startCmd = (state == ST_IDLE) && flashRdy && (commitPend || holdFull);
  assign frameEnd = (state == ST_SHIFT) && spiDone &&
                    (byteNo == (isCommit ? COMMIT_LAST_BYTE : WRITE_LAST_BYTE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      byteNo     <= '0;
      isCommit   <= 1'b0;
      commitPend <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startCmd) begin
          isCommit <= commitPend;
          byteNo   <= '0;
          state    <= ST_LOAD;
        end
        ST_LOAD: state <= ST_SHIFT;
        ST_SHIFT: if (spiDone) begin
          if (frameEnd) begin
            state <= ST_END;
            if (isCommit) commitPend <= 1'b0;
            else if (lastInPage) commitPend <= 1'b1;
          end else begin
            byteNo <= byteNo + 3'd1;
            state  <= ST_LOAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.pop      = startCmd && !commitPend;
    strb.advance  = frameEnd && !isCommit;
    strb.pageDone = frameEnd && isCommit;
    strb.isCommit = isCommit;
    strb.byteSel  = byteNo;
  end

  assign spiLoad = (state == ST_LOAD);
  assign spiCsN  = !((state == ST_LOAD) || (state == ST_SHIFT));

  a_r9_start_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> $past(flashRdy));
  a_r3_cs_rise_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> !spiBusy);
endmodule

// File: rtl/rec_flash_writer.sv
module rec_flash_writer
  import rfw_pkg::*;
#(
  parameter int SAMPLE_W   = 10,
  parameter int OFFSET     = 'h1D5,
  parameter int PAGE_BYTES = 528,
  parameter int PAGE_COUNT = 4096,
  parameter int SCK_DIV    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                recordEn,
  input  logic                newRec,
  input  logic                flashRdy,
  input  logic                spiMiso,
  output logic                spiCsN,
  output logic                spiSck,
  output logic                spiMosi,
  output logic                overrun
);
  ctrl_strobes_t strb;
  logic       holdFull;
  logic       lastInPage;
  logic [7:0] frameByte;
  logic       spiLoad;
  logic       spiDone;
  logic       spiBusy;

  rfw_datapath #(
    .SAMPLE_W(SAMPLE_W), .OFFSET(OFFSET),
    .PAGE_BYTES(PAGE_BYTES), .PAGE_COUNT(PAGE_COUNT)
  ) uDp (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .recordEn(recordEn), .newRec(newRec), .strb(strb), .holdFull(holdFull),
    .lastInPage(lastInPage), .frameByte(frameByte), .overrun(overrun)
  );

  rfw_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .flashRdy(flashRdy), .holdFull(holdFull),
    .lastInPage(lastInPage), .spiDone(spiDone), .spiBusy(spiBusy),
    .strb(strb), .spiLoad(spiLoad), .spiCsN(spiCsN)
  );

  rfw_spi_tx #(.DIV(SCK_DIV)) uSpi (
    .clk(clk), .rstN(rstN), .load(spiLoad), .loadByte(frameByte),
    .spiMiso(spiMiso), .spiSck(spiSck), .spiMosi(spiMosi),
    .busy(spiBusy), .done(spiDone)
  );
endmodule

// File: tb/sim_rec_flash_writer.sv
module sim_rec_flash_writer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleValid = 1'b0;
  logic [9:0] sampleData = '0;
  logic       recordEn = 1'b0;
  logic       newRec = 1'b0;
  logic       flashRdy = 1'b1;
  logic       spiMiso = 1'b1;
  logic       spiCsN, spiSck, spiMosi, overrun;

  always #2 clk = ~clk;  // 250 MHz

  rec_flash_writer #(.PAGE_BYTES(4), .PAGE_COUNT(3)) u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .recordEn(recordEn), .newRec(newRec), .flashRdy(flashRdy), .spiMiso(spiMiso),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi), .overrun(overrun)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Frame capture from the pins
  logic [7:0] fByte [0:63][0:4];
  int  fLen [0:63];
  int  fCnt = 0;
  int  bitN = 0;
  logic [7:0] shAcc = '0;
  bit  monOn = 1'b0;
  int  modeErr = 0, perErr = 0, partErr = 0;
  realtime lastRise = 0;

  always @(negedge spiCsN) if (monOn) begin
    if (spiSck !== 1'b1) modeErr++;
    bitN = 0;
  end
  always @(posedge spiSck) if (monOn && spiCsN === 1'b0) begin
    shAcc = {shAcc[6:0], spiMosi};
    bitN++;
    if (bitN % 8 != 1 && ($realtime - lastRise) != 16.0) perErr++;
    lastRise = $realtime;
    if (bitN % 8 == 0 && bitN <= 40 && fCnt < 64) fByte[fCnt][bitN/8-1] = shAcc;
  end
  always @(posedge spiCsN) if (monOn) begin
    if (bitN % 8 != 0) partErr++;
    if (fCnt < 64) fLen[fCnt] = bitN / 8;
    fCnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expectFrame(input int idx, input int len, input logic [7:0] b0,
      input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3,
      input logic [7:0] b4, input string tag);
    logic [7:0] exp [0:4];
    exp[0] = b0; exp[1] = b1; exp[2] = b2; exp[3] = b3; exp[4] = b4;
    check(fCnt > idx, {tag, " frame present"}, fCnt, idx + 1);
    if (fCnt > idx) begin
      check(fLen[idx] == len, {tag, " frame length"}, fLen[idx], len);
      for (int i = 0; i < len; i++)
        check(fByte[idx][i] == exp[i], {tag, " frame byte"}, fByte[idx][i], exp[i]);
    end
  endtask

  task automatic sendSample(input logic [9:0] v, input int gap);
    @(negedge clk); sampleValid = 1'b1; sampleData = v;
    @(negedge clk); sampleValid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulseNewRec();
    @(negedge clk); newRec = 1'b1;
    @(negedge clk); newRec = 1'b0;
  endtask

  task automatic testReset();  // R1
    @(negedge clk);
    check(spiCsN === 1'b1, "R1 cs idle in reset", spiCsN, 1);
    check(spiSck === 1'b1, "R1 sck idle in reset", spiSck, 1);
    rstN = 1'b1; monOn = 1'b1;
    repeat (20) @(negedge clk);
    check(overrun === 1'b0, "R1 overrun after reset", overrun, 0);
    check(fCnt == 0, "R1 no frame after reset", fCnt, 0);
  endtask

  task automatic testIgnoreDisabled();  // R10
    recordEn = 1'b0;
    sendSample(10'h100, 300);
    check(fCnt == 0, "R10 sample ignored while disabled", fCnt, 0);
    check(overrun === 1'b0, "R10 no overrun while disabled", overrun, 0);
  endtask

  task automatic testFirstPage();  // R2 R3 R5 R6
    pulseNewRec();
    recordEn = 1'b1;
    sendSample(10'h211, 250);
    sendSample(10'h000, 250);
    sendSample(10'h3FF, 250);
    sendSample(10'h1D4, 450);
    expectFrame(0, 5, 8'h84, 8'h00, 8'h00, 8'h00, 8'h3C, "R2 R3 R6 mid sample");
    expectFrame(1, 5, 8'h84, 8'h00, 8'h00, 8'h01, 8'h2B, "R2 zero sample");
    expectFrame(2, 5, 8'h84, 8'h00, 8'h00, 8'h02, 8'h2A, "R2 max sample");
    expectFrame(3, 5, 8'h84, 8'h00, 8'h00, 8'h03, 8'hFF, "R2 below offset");
    expectFrame(4, 4, 8'h88, 8'h00, 8'h00, 8'h00, 8'h00, "R5 commit page 0");
  endtask

  task automatic testAppend();  // R7 R5
    sendSample(10'h1D5, 250);
    sendSample(10'h1E5, 250);
    recordEn = 1'b0;
    repeat (50) @(negedge clk);
    recordEn = 1'b1;
    sendSample(10'h2D4, 250);
    sendSample(10'h255, 450);
    expectFrame(5, 5, 8'h84, 8'h00, 8'h00, 8'h00, 8'h00, "R7 page 1 start");
    expectFrame(7, 5, 8'h84, 8'h00, 8'h00, 8'h02, 8'hFF, "R7 append after pause");
    expectFrame(8, 5, 8'h84, 8'h00, 8'h00, 8'h03, 8'h80, "R7 append last byte");
    expectFrame(9, 4, 8'h88, 8'h00, 8'h04, 8'h00, 8'h00, "R5 commit page 1");
  endtask

  task automatic testFull();  // R8
    for (int i = 1; i <= 4; i++) sendSample(10'h1D5 + 10'(i), (i == 4) ? 450 : 250);
    expectFrame(13, 5, 8'h84, 8'h00, 8'h00, 8'h03, 8'h04, "R8 last byte of memory");
    expectFrame(14, 4, 8'h88, 8'h00, 8'h08, 8'h00, 8'h00, "R8 commit last page");
    sendSample(10'h2AA, 300);
    check(fCnt == 15, "R8 sample dropped when full", fCnt, 15);
    recordEn = 1'b0;
    repeat (20) @(negedge clk);
    recordEn = 1'b1;
    sendSample(10'h2AB, 300);
    check(fCnt == 15, "R8 still dropped after re-enable", fCnt, 15);
    check(overrun === 1'b0, "R8 no overrun when full", overrun, 0);
  endtask

  task automatic testRestart();  // R6
    pulseNewRec();
    sendSample(10'h1E0, 250);
    expectFrame(15, 5, 8'h84, 8'h00, 8'h00, 8'h00, 8'h0B, "R6 restart at zero");
  endtask

  task automatic testReady();  // R9
    flashRdy = 1'b0;
    sendSample(10'h1F0, 300);
    check(fCnt == 16, "R9 held while busy", fCnt, 16);
    check(spiCsN === 1'b1, "R9 cs high while busy", spiCsN, 1);
    flashRdy = 1'b1;
    repeat (250) @(negedge clk);
    expectFrame(16, 5, 8'h84, 8'h00, 8'h00, 8'h01, 8'h1B, "R9 sent after ready");
  endtask

  task automatic testOverrun();  // R11
    @(negedge clk); sampleValid = 1'b1; sampleData = 10'h200;
    @(negedge clk); sampleData = 10'h201;
    @(negedge clk); sampleData = 10'h202;
    @(negedge clk); sampleValid = 1'b0;
    repeat (5) @(negedge clk);
    check(overrun === 1'b1, "R11 overrun set", overrun, 1);
    repeat (700) @(negedge clk);
    expectFrame(17, 5, 8'h84, 8'h00, 8'h00, 8'h02, 8'h2B, "R11 first kept");
    expectFrame(18, 5, 8'h84, 8'h00, 8'h00, 8'h03, 8'h2C, "R11 held kept");
    expectFrame(19, 4, 8'h88, 8'h00, 8'h00, 8'h00, 8'h00, "R11 commit after held");
    check(fCnt == 20, "R11 third sample dropped", fCnt, 20);
    check(overrun === 1'b1, "R11 overrun sticky", overrun, 1);
    recordEn = 1'b0;
    repeat (2) @(negedge clk);
    check(overrun === 1'b0, "R11 overrun cleared by disable", overrun, 0);
  endtask

  task automatic testLink();  // R4
    check(modeErr == 0, "R4 sck high at cs fall", modeErr, 0);
    check(perErr == 0, "R4 sck period four clocks", perErr, 0);
    check(partErr == 0, "R4 whole bytes per frame", partErr, 0);
  endtask

  initial begin
    testReset();
    testIgnoreDisabled();
    testFirstPage();
    testAppend();
    testFull();
    testRestart();
    testReady();
    testOverrun();
    testLink();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule